// File: doc/BRIEF.md
# Integer Execute Unit with Set-Less-Than

This block is the purely combinational execute stage of a small 32-bit load/store processor. Each operation takes two register values, a 16-bit constant taken from the instruction, a 5-bit shift count and a 4-bit operation code. From these it forms one 32-bit result and a flag that is high when that result is zero.

The operations cover wrap-around add and subtract, adding a constant, bitwise logic, logical shifts and loading a constant into the upper half of the word. Compares come in signed and unsigned forms, each taking either a register or a constant, and each writes the value 0 or 1. NOT is done as NOR against a zero operand. Branch logic outside the block tests the zero flag after a subtract to decide equal or not-equal. There is no register file, no fetch, no multiply or divide and no overflow trap.

Top module: `int_exec_unit`

## Requirements
- R1: Code 0 gives opa + opb and code 1 gives opa - opb, both modulo 2^32, with no overflow indication (0x7FFFFFFF + 1 = 0x80000000, 0xFFFFFFFF + 1 = 0).
- R2: Code 2 adds opa to the constant sign-extended from its bit 15, so constant 0xFFFF subtracts one; opb is ignored.
- R3: Code 3 is AND, code 4 is OR, and code 5 is NOT(opa OR opb); code 5 with opb = 0 gives the inverse of opa.
- R4: Code 6 (AND with constant) and code 7 (OR with constant) zero-extend the 16-bit constant.
- R5: Code 8 shifts opa left and code 9 shifts opa right by shamt positions (0 to 31), filling vacated bits with zeros; shamt 0 passes opa through unchanged.
- R6: Code 10 writes 1 when opa < opb as two's-complement values, else 0; code 11 makes the same compare as unsigned values (0xFFFFFFFF vs 1 gives 1 signed, 0 unsigned).
- R7: Code 12 (signed) and code 13 (unsigned) compare opa with the sign-extended constant and write 1 or 0; under code 13 the constant 0xFFFF stands for 0xFFFFFFFF.
- R8: Code 14 places the constant in result bits 31:16 and clears bits 15:0.
- R9: The zero output is 1 exactly when the 32-bit result is 0.
- R10: Code 15 is unused and yields result 0 with zero = 1 whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| cnst | input | 16 | Constant field of the instruction |
| shamt | input | 5 | Shift count |
| op | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is zero |

## Verification
The bench builds the unit with its default widths: a 32-bit data word and a 16-bit constant, which makes the shift count 5 bits. At these values the bench can reach the sign-bit boundary at bit 31 and the full shift range up to 31 positions. It can also reach the 0xFFFFFFFF pattern that reads as -1 in a signed compare and as the largest value in an unsigned one. The sign extension and zero extension of bit 15 of the constant can be seen directly in the result.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic [W-1:0]           opa,
  input  logic [W-1:0]           opb,
  input  logic [IW-1:0]          cnst,
  input  logic [$clog2(W)-1:0]   shamt,
  input  logic [3:0]             op,
  output logic [W-1:0]           result,
  output logic                   zero
);
  localparam int SW = $clog2(W);
  localparam int XW = W - IW;

  localparam logic [3:0] OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_ADDI = 4'd2,
                         OP_AND  = 4'd3,  OP_OR   = 4'd4,  OP_NOR  = 4'd5,
                         OP_ANDI = 4'd6,  OP_ORI  = 4'd7,  OP_SLL  = 4'd8,
                         OP_SRL  = 4'd9,  OP_SLT  = 4'd10, OP_SLTU = 4'd11,
                         OP_SLTI = 4'd12, OP_SLTIU= 4'd13, OP_LUI  = 4'd14;

  logic [W-1:0] sx, zx, rhs, sum;
  logic         use_imm, sub, lt_s, lt_u;

  assign sx      = {{XW{cnst[IW-1]}}, cnst};
  assign zx      = {{XW{1'b0}}, cnst};
  assign use_imm = (op == OP_ADDI) || (op == OP_SLTI) || (op == OP_SLTIU);
  assign rhs     = use_imm ? sx : opb;
  assign sub     = (op == OP_SUB);
  assign sum     = sub ? (opa - rhs) : (opa + rhs);
  assign lt_s    = $signed(opa) < $signed(rhs);
  assign lt_u    = opa < rhs;

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_ADDI: result = sum;
      OP_AND:                  result = opa & opb;
      OP_OR:                   result = opa | opb;
      OP_NOR:                  result = ~(opa | opb);
      OP_ANDI:                 result = opa & zx;
      OP_ORI:                  result = opa | zx;
      OP_SLL:                  result = opa << shamt;
      OP_SRL:                  result = opa >> shamt;
      OP_SLT, OP_SLTI:         result = {{(W-1){1'b0}}, lt_s};
      OP_SLTU, OP_SLTIU:       result = {{(W-1){1'b0}}, lt_u};
      OP_LUI:                  result = {cnst, {XW{1'b0}}};
      default:                 result = '0;
    endcase
  end

  assign zero = (result == '0);

  always_comb begin
    if (!$isunknown({opa, opb, cnst, shamt, op})) begin
      if (op == OP_ADD)  AST_ADD_WRAP: assert (result - opb == opa);             // R1
      if (op == OP_SUB)  AST_SUB_WRAP: assert (result + opb == opa);             // R1
      if (op == OP_ADDI) AST_ADDI_SEXT: assert ((result - opa) == sx);           // R2
      if (op == OP_NOR)  AST_NOR_DISJOINT: assert ((result & (opa | opb)) == '0); // R3
      if (op == OP_ANDI || op == OP_ORI)
        AST_IMM_UPPER: assert (result[W-1:IW] == (op == OP_ORI ? opa[W-1:IW] : '0)); // R4
      if (op == OP_SLT || op == OP_SLTU || op == OP_SLTI || op == OP_SLTIU)
        AST_CMP_BOOL: assert (result[W-1:1] == '0);                              // R6
      if (op == OP_LUI)  AST_LUI_FIELDS: assert (result[W-1:XW] == cnst && result[XW-1:0] == '0); // R8
      if (op == 4'd15)   AST_UNUSED_ZERO: assert (result == '0 && zero);         // R10
      AST_SHIFT_KEEP: assert (!((op == OP_SLL || op == OP_SRL) && shamt == '0) || result == opa); // R5
    end
  end
endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] opa, opb, result;
  logic [15:0] cnst;
  logic [4:0]  shamt;
  logic [3:0]  op;
  logic        zero;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  int_exec_unit u0 (.opa(opa), .opb(opb), .cnst(cnst), .shamt(shamt),
                    .op(op), .result(result), .zero(zero));

  // {req, op, opa, opb, cnst, shamt, expected}
  localparam int NV = 22;
  localparam logic [124:0] VEC [NV] = '{
    {4'd1,  4'd0,  32'h7FFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h80000000},  // R1
    {4'd1,  4'd0,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000000},  // R1
    {4'd1,  4'd1,  32'h00000005, 32'h00000007, 16'h0000, 5'd0,  32'hFFFFFFFE},  // R1
    {4'd2,  4'd2,  32'h0000000A, 32'h0000DEAD, 16'hFFFF, 5'd0,  32'h00000009},  // R2
    {4'd2,  4'd2,  32'h00000000, 32'h00000000, 16'h8000, 5'd0,  32'hFFFF8000},  // R2
    {4'd3,  4'd3,  32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 5'd0,  32'hF000F000},  // R3
    {4'd3,  4'd4,  32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 5'd0,  32'hFFF0FFF0},  // R3
    {4'd3,  4'd5,  32'h0000FFFF, 32'h00000000, 16'h0000, 5'd0,  32'hFFFF0000},  // R3
    {4'd4,  4'd6,  32'hFFFFFFFF, 32'h00000000, 16'h8001, 5'd0,  32'h00008001},  // R4
    {4'd4,  4'd7,  32'h00000000, 32'h00000000, 16'hF000, 5'd0,  32'h0000F000},  // R4
    {4'd5,  4'd8,  32'h00000001, 32'h00000000, 16'h0000, 5'd31, 32'h80000000},  // R5
    {4'd5,  4'd9,  32'h80000000, 32'h00000000, 16'h0000, 5'd31, 32'h00000001},  // R5
    {4'd5,  4'd9,  32'hFFFFFFFF, 32'h00000000, 16'h0000, 5'd4,  32'h0FFFFFFF},  // R5
    {4'd5,  4'd8,  32'h12345678, 32'h00000000, 16'h0000, 5'd0,  32'h12345678},  // R5
    {4'd6,  4'd10, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000001},  // R6
    {4'd6,  4'd11, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000000},  // R6
    {4'd6,  4'd10, 32'h00000042, 32'h00000042, 16'h0000, 5'd0,  32'h00000000},  // R6
    {4'd7,  4'd12, 32'hFFFFFFFE, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000001},  // R7
    {4'd7,  4'd13, 32'h00000005, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000001},  // R7
    {4'd7,  4'd13, 32'hFFFFFFFF, 32'h00000000, 16'h0001, 5'd0,  32'h00000000},  // R7
    {4'd8,  4'd14, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hABCD, 5'd0,  32'hABCD0000},  // R8
    {4'd10, 4'd15, 32'hFFFFFFFF, 32'h12345678, 16'hFFFF, 5'd7,  32'h00000000}   // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] c, input logic [4:0] s);
    @(negedge clk);
    op = o; opa = a; opb = b; cnst = c; shamt = s;
    #1;
  endtask

  initial begin
    op = 4'd0; opa = '0; opb = '0; cnst = '0; shamt = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset idle result", result, 32'h0);
    chk("R9 reset idle zero", {31'b0, zero}, 32'h1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [124:0] v;
      v = VEC[i];
      apply(v[120:117], v[116:85], v[84:53], v[52:37], v[36:32]);
      chk($sformatf("R%0d vec %0d result", v[124:121], i), result, v[31:0]);
      chk($sformatf("R9 vec %0d zero", i), {31'b0, zero}, {31'b0, (v[31:0] == 32'h0)});
    end

    // R3: NOT via NOR with zero
    apply(4'd5, 32'hA5A5_0F0F, 32'h0, 16'h0, 5'd0);
    chk("R3 not", result, 32'h5A5A_F0F0);
    // R1: subtract equal operands -> zero flag for branch-equal
    apply(4'd1, 32'hCAFEBABE, 32'hCAFEBABE, 16'h0, 5'd0);
    chk("R1 sub equal", result, 32'h0);
    chk("R9 sub equal zero", {31'b0, zero}, 32'h1);
    // R9: nonzero result clears flag
    apply(4'd1, 32'h1, 32'h0, 16'h0, 5'd0);
    chk("R9 nonzero flag", {31'b0, zero}, 32'h0);
    // R2: opb ignored by add-constant
    apply(4'd2, 32'h100, 32'hFFFF_FFFF, 16'h0010, 5'd0);
    chk("R2 opb ignored", result, 32'h110);
    // R6: most-negative vs most-positive
    apply(4'd10, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0);
    chk("R6 signed extremes", result, 32'h1);
    apply(4'd11, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0);
    chk("R6 unsigned extremes", result, 32'h0);
    // R10: unused code with other operands
    apply(4'd15, 32'h0000_0001, 32'h0, 16'h1234, 5'd1);
    chk("R10 unused", result, 32'h0);
    chk("R10 unused zero", {31'b0, zero}, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule